// File: doc/BRIEF.md
# Capture Word FIFO with Threshold Request

This block buffers 32-bit words produced by an image capture path until a bus-side reader collects them. Words enter through a write strobe and leave through a read strobe, in arrival order, from a 128-entry store. The reader learns how full the store is from a level output. A peak output holds the highest occupancy seen. Both storage pointers are brought out for inspection.

A 7-bit threshold field, together with a request enable, drives a request line that tells a DMA engine to start draining. Five sticky event flags record the store's conditions and faults. Each flag is cleared by writing a 1 to its bit, and each can be masked out of a single registered interrupt line. A soft reset strobe runs a small sequencer through a multi-cycle clearing phase. A done flag shows when that phase has finished.

The sequencer has two states. CLEAR is entered on hardware reset and on a soft reset strobe while in RUN. It holds the datapath cleared for CLR_CYCLES clock edges and then moves to RUN. RUN is the normal operating state, and it returns to CLEAR only on a soft reset strobe.

Top module: `cap_word_fifo`

## Requirements
- R1: Accepted words are read back in write order; `rd_data` takes the read word on the clock edge that samples `rd_en` and holds it until the next read.
- R2: `level` counts stored words from 0 to 128; `wr_ptr` and `rd_ptr` advance by one per accepted write or read and wrap from 127 to 0.
- R3: A write while the level is 128 and no read is made in that cycle is discarded: `wr_ptr` and `level` do not change and overflow (status bit 1) is set. A write and a read in the same cycle at level 128 both succeed, and the level stays 128.
- R4: A read while the level is 0 leaves `rd_ptr` unchanged, loads 0 into `rd_data`, and sets underflow (status bit 0). A write made in the same cycle is still accepted.
- R5: `dma_req` is high exactly when `dma_en` is 1 and `level` is at least `thr_field`+1, so a field value of 0 means 1 word and 127 means 128 words.
- R6: `peak` holds the largest `level` seen since the last reset and never decreases outside a reset.
- R7: Status bits are sticky. Bit 0 is underflow, bit 1 overflow, bit 2 threshold reached (level at least `thr_field`+1, independent of `dma_en`), bit 3 full (level 128), and bit 4 not-empty (level above 0). The level-based bits are set one cycle after `level` meets their condition.
- R8: A cycle with `evt_clr_wr` high clears every status bit whose `evt_clr_data` bit is 1 and leaves the others unchanged. If the event's condition still holds in that cycle, the bit stays set.
- R9: `irq` is a register loaded each cycle with the OR of `evt_status` AND `evt_enable`; a 0 enable bit masks its event.
- R10: In the CLEAR state `reset_done` is 0, read and write strobes are ignored, and pointers, level, peak, read data, status and `irq` are cleared. CLEAR lasts CLR_CYCLES (default 4) edges after hardware reset or after a `soft_rst` strobe sampled in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset strobe |
| wr_en | input | 1 | Write strobe from the capture side |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read strobe from the register side |
| rd_data | output | 32 | Last word read (0 after an empty read) |
| dma_en | input | 1 | Request line enable |
| thr_field | input | 7 | Threshold minus one |
| dma_req | output | 1 | DMA request |
| level | output | 8 | Words currently stored |
| peak | output | 8 | Highest level since reset |
| wr_ptr | output | 7 | Write pointer |
| rd_ptr | output | 7 | Read pointer |
| evt_status | output | 5 | Sticky event flags |
| evt_clr_wr | input | 1 | Clear strobe for status bits |
| evt_clr_data | input | 5 | Bits to clear (1 clears) |
| evt_enable | input | 5 | Per-event interrupt enables |
| irq | output | 1 | Registered masked interrupt |
| reset_done | output | 1 | 1 when the sequencer is in RUN |

## Verification
Read and write strobes can land in the same cycle exactly at the store's edges. The bench fills the store to 128 words and then issues a combined read and write. It expects the oldest word out, an unchanged level of 128, and the new word to reappear last during the drain. At level 0 the combined strobe must yield a zero read and an underflow flag, while the written word is still counted. A flag clear that coincides with a still-true level condition is also provoked, by clearing not-empty while a word is stored; the flag must remain set.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic {
        SEQ_CLEAR,
        SEQ_RUN
    } seq_state_e;

    localparam int EV_UNDER  = 0;
    localparam int EV_OVER   = 1;
    localparam int EV_THR    = 2;
    localparam int EV_FULL   = 3;
    localparam int EV_NEMPTY = 4;
    localparam int EV_COUNT  = 5;
endpackage

// File: rtl/cwf_reset_seq.sv
module cwf_reset_seq
    import cwf_pkg::*;
#(
    parameter int CLR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    output logic clr,
    output logic done
);
    localparam int CW = (CLR_CYCLES < 2) ? 1 : $clog2(CLR_CYCLES + 1);

    seq_state_e      state_q;
    logic [CW-1:0]   cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_CLEAR;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_CLEAR: begin
                    if (cnt_q == CW'(CLR_CYCLES - 1)) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (soft_rst) begin
                        state_q <= SEQ_CLEAR;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= SEQ_CLEAR;
            endcase
        end
    end

    // outputs
    always_comb begin
        clr  = 1'b0;
        done = 1'b0;
        unique case (state_q)
            SEQ_CLEAR: clr  = 1'b1;
            SEQ_RUN:   done = 1'b1;
            default:   clr  = 1'b1;
        endcase
    end

    assert_soft_rst_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && soft_rst) |=> !done);
endmodule

// File: rtl/cwf_store.sv
module cwf_store #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    level,
    output logic [AW-1:0]    wr_ptr,
    output logic [AW-1:0]    rd_ptr,
    output logic             ovf_pulse,
    output logic             udf_pulse
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [LW-1:0]    level_q;
    logic [WIDTH-1:0] rd_data_q;
    logic             rd_ok, wr_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        rd_ok     = !clr && rd_en && (level_q != '0);
        wr_ok     = !clr && wr_en && ((level_q != LW'(DEPTH)) || rd_ok);
        ovf_pulse = !clr && wr_en && !wr_ok;
        udf_pulse = !clr && rd_en && (level_q == '0);
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            level_q   <= '0;
            rd_data_q <= '0;
        end else if (clr) begin
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            level_q   <= '0;
            rd_data_q <= '0;
        end else begin
            if (wr_ok) wr_ptr_q <= bump(wr_ptr_q);
            if (rd_ok) begin
                rd_ptr_q  <= bump(rd_ptr_q);
                rd_data_q <= mem[rd_ptr_q];
            end else if (udf_pulse) begin
                rd_data_q <= '0;
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign rd_data = rd_data_q;
    assign level   = level_q;
    assign wr_ptr  = wr_ptr_q;
    assign rd_ptr  = rd_ptr_q;

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(DEPTH));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && wr_en && !rd_en && level_q == LW'(DEPTH)) |=> ($stable(wr_ptr_q) && $stable(level_q)));
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rd_en && level_q == '0) |=> ($stable(rd_ptr_q) && rd_data_q == '0));
endmodule

// File: rtl/cwf_events.sv
module cwf_events #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    input  logic [N-1:0] enable,
    output logic [N-1:0] status,
    output logic         irq
);
    logic irq_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  flag_q <= 1'b0;
            else if (clr)                flag_q <= 1'b0;
            else if (set_vec[i])         flag_q <= 1'b1;
            else if (clr_wr && clr_data[i]) flag_q <= 1'b0;
        end
        assign status[i] = flag_q;

        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !clr && !(clr_wr && clr_data[i])) |=> flag_q);
        assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_data[i] && !set_vec[i]) |=> !flag_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   irq_q <= 1'b0;
        else if (clr) irq_q <= 1'b0;
        else          irq_q <= |(status & enable);
    end
    assign irq = irq_q;

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & enable) == '0) |=> !irq_q);
endmodule

// File: rtl/cap_word_fifo.sv
module cap_word_fifo
    import cwf_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int WIDTH      = 32,
    parameter int CLR_CYCLES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [WIDTH-1:0]    wr_data,
    input  logic                rd_en,
    output logic [WIDTH-1:0]    rd_data,
    input  logic                dma_en,
    input  logic [AW-1:0]       thr_field,
    output logic                dma_req,
    output logic [LW-1:0]       level,
    output logic [LW-1:0]       peak,
    output logic [AW-1:0]       wr_ptr,
    output logic [AW-1:0]       rd_ptr,
    output logic [EV_COUNT-1:0] evt_status,
    input  logic                evt_clr_wr,
    input  logic [EV_COUNT-1:0] evt_clr_data,
    input  logic [EV_COUNT-1:0] evt_enable,
    output logic                irq,
    output logic                reset_done
);
    logic                clr;
    logic                ovf_pulse, udf_pulse;
    logic                thr_hit;
    logic [LW-1:0]       peak_q;
    logic [EV_COUNT-1:0] set_vec;

    cwf_reset_seq #(.CLR_CYCLES(CLR_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .clr      (clr),
        .done     (reset_done)
    );

    cwf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .level     (level),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .ovf_pulse (ovf_pulse),
        .udf_pulse (udf_pulse)
    );

    assign thr_hit = (level >= (LW'(thr_field) + LW'(1)));
    assign dma_req = dma_en && thr_hit;

    always_comb begin
        set_vec            = '0;
        set_vec[EV_UNDER]  = udf_pulse;
        set_vec[EV_OVER]   = ovf_pulse;
        set_vec[EV_THR]    = thr_hit;
        set_vec[EV_FULL]   = (level == LW'(DEPTH));
        set_vec[EV_NEMPTY] = (level != '0);
    end

    cwf_events #(.N(EV_COUNT)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .set_vec  (set_vec),
        .clr_wr   (evt_clr_wr),
        .clr_data (evt_clr_data),
        .enable   (evt_enable),
        .status   (evt_status),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             peak_q <= '0;
        else if (clr)           peak_q <= '0;
        else if (level > peak_q) peak_q <= level;
    end
    assign peak = peak_q;

    assert_peak_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (peak_q >= $past(peak_q)));
    assert_clear_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && $past(clr)) |-> (level == '0 && evt_status == '0));
endmodule

// File: tb/sim_cap_word_fifo.sv
`timescale 1ns/1ps
module sim_cap_word_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        dma_en = 1'b0;
    logic [6:0]  thr_field = 7'd127;
    logic        dma_req;
    logic [7:0]  level, peak;
    logic [6:0]  wr_ptr, rd_ptr;
    logic [4:0]  evt_status;
    logic        evt_clr_wr = 1'b0;
    logic [4:0]  evt_clr_data = '0;
    logic [4:0]  evt_enable = '0;
    logic        irq, reset_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] mq[$];

    always #2 clk = ~clk;

    cap_word_fifo u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .dma_en(dma_en), .thr_field(thr_field), .dma_req(dma_req),
        .level(level), .peak(peak), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .evt_status(evt_status), .evt_clr_wr(evt_clr_wr),
        .evt_clr_data(evt_clr_data), .evt_enable(evt_enable),
        .irq(irq), .reset_done(reset_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_word(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        if (mq.size() < 128) mq.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_word(output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic both(input logic [31:0] w, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic clr_flags(input logic [4:0] v);
        @(negedge clk);
        evt_clr_wr = 1'b1; evt_clr_data = v;
        @(negedge clk);
        evt_clr_wr = 1'b0; evt_clr_data = '0;
        idle(2);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic t_reset();
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 done low during clear", 32'(reset_done), 32'd0);
        idle(6);
        chk("R10 done after clear", 32'(reset_done), 32'd1);
        chk("R2 level at reset", 32'(level), 32'd0);
        chk("R7 status at reset", 32'(evt_status), 32'd0);
        chk("R9 irq at reset", 32'(irq), 32'd0);
        chk("R1 rd_data at reset", rd_data, 32'd0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) wr_word(32'hA5A50000 + 32'(i * 17));
        chk("R2 level after 5 writes", 32'(level), 32'd5);
        chk("R2 wr_ptr after 5 writes", 32'(wr_ptr), 32'd5);
        for (int i = 0; i < 5; i++) begin
            rd_word(d);
            chk("R1 read order", d, mq.pop_front());
        end
        chk("R2 rd_ptr after 5 reads", 32'(rd_ptr), 32'd5);
        chk("R2 level after drain", 32'(level), 32'd0);
        idle(2);
        chk("R6 peak five", 32'(peak), 32'd5);
    endtask

    task automatic t_dma();
        logic [31:0] d;
        thr_field = 7'd2; dma_en = 1'b1;
        wr_word(32'h11); wr_word(32'h22);
        chk("R5 below threshold", 32'(dma_req), 32'd0);
        wr_word(32'h33);
        chk("R5 at threshold", 32'(dma_req), 32'd1);
        @(negedge clk); dma_en = 1'b0; #1;
        chk("R5 disabled", 32'(dma_req), 32'd0);
        dma_en = 1'b1; thr_field = 7'd127; #1;
        chk("R5 field 127 means 128", 32'(dma_req), 32'd0);
        dma_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rd_word(d);
            chk("R1 read order dma", d, mq.pop_front());
        end
    endtask

    task automatic t_full();
        logic [7:0]  wp;
        logic [31:0] d;
        clr_flags(5'b11111);
        chk("R8 all cleared", 32'(evt_status), 32'd0);
        for (int i = 0; i < 128; i++) wr_word(32'hC0DE0000 + 32'(i));
        chk("R2 level full", 32'(level), 32'd128);
        idle(3);
        chk("R7 full flag", 32'(evt_status[3]), 32'd1);
        chk("R7 no overflow yet", 32'(evt_status[1]), 32'd0);
        wp = 8'(wr_ptr);
        wr_word(32'hDEADBEEF);
        chk("R3 wr_ptr held", 32'(wr_ptr), 32'(wp));
        chk("R3 level held", 32'(level), 32'd128);
        idle(3);
        chk("R3 overflow flag", 32'(evt_status[1]), 32'd1);
        chk("R6 peak 128", 32'(peak), 32'd128);
        both(32'hB0B0B0B0, d);
        chk("R3 read at full", d, mq.pop_front());
        mq.push_back(32'hB0B0B0B0);
        chk("R3 level after read+write", 32'(level), 32'd128);
        for (int i = 0; i < 128; i++) begin
            rd_word(d);
            chk("R1 drain order", d, mq.pop_front());
        end
        chk("R2 level drained", 32'(level), 32'd0);
    endtask

    task automatic t_under();
        logic [6:0]  rp;
        logic [31:0] d;
        rp = rd_ptr;
        rd_word(d);
        chk("R4 empty read data", d, 32'd0);
        chk("R4 rd_ptr held", 32'(rd_ptr), 32'(rp));
        idle(2);
        chk("R4 underflow flag", 32'(evt_status[0]), 32'd1);
        both(32'h5A5A5A5A, d);
        chk("R4 empty read+write data", d, 32'd0);
        chk("R4 write accepted", 32'(level), 32'd1);
        rd_word(d);
        chk("R1 read after empty", d, 32'h5A5A5A5A);
        idle(3);
    endtask

    task automatic t_w1c();
        clr_flags(5'b00010);
        chk("R8 clear only overflow", 32'(evt_status), 32'b11101);
        clr_flags(5'b00000);
        chk("R8 zero leaves flags", 32'(evt_status), 32'b11101);
        clr_flags(5'b11111);
        chk("R8 clear all", 32'(evt_status), 32'd0);
        wr_word(32'h77);
        idle(3);
        clr_flags(5'b10000);
        chk("R8 set wins over clear", 32'(evt_status[4]), 32'd1);
        begin
            logic [31:0] d;
            rd_word(d);
            chk("R1 single word", d, 32'h77);
        end
        void'(mq.pop_front());
        idle(2);
        clr_flags(5'b11111);
        chk("R8 clear after drain", 32'(evt_status), 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        evt_enable = '0;
        rd_word(d);
        idle(3);
        chk("R7 underflow for irq", 32'(evt_status), 32'd1);
        chk("R9 masked", 32'(irq), 32'd0);
        evt_enable = 5'b00001;
        idle(2);
        chk("R9 enabled event", 32'(irq), 32'd1);
        evt_enable = 5'b11110;
        idle(2);
        chk("R9 other enables", 32'(irq), 32'd0);
        evt_enable = 5'b00001;
        clr_flags(5'b00001);
        idle(1);
        chk("R9 irq after clear", 32'(irq), 32'd0);
    endtask

    task automatic t_soft();
        for (int i = 0; i < 4; i++) wr_word(32'h900 + 32'(i));
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R10 done drops", 32'(reset_done), 32'd0);
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 32'hFFFF;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        idle(6);
        mq.delete();
        chk("R10 done back", 32'(reset_done), 32'd1);
        chk("R10 level cleared", 32'(level), 32'd0);
        chk("R10 peak cleared", 32'(peak), 32'd0);
        chk("R10 pointers cleared", 32'({wr_ptr, rd_ptr}), 32'd0);
        chk("R10 status cleared", 32'(evt_status), 32'd0);
        chk("R10 irq cleared", 32'(irq), 32'd0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_dma();
        t_full();
        t_under();
        t_w1c();
        t_irq();
        t_soft();
        finished = 1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end
endmodule